// File: doc/BRIEF.md
# Clock Divider and Gating Tree

This block turns one master clock into a family of clock-enable pulses for a system-on-chip: a reference enable, a CPU enable, AHB and APB bus enables, a flash-interface enable, a baud-rate enable, an external-memory bus enable, an SRAM enable and a set of per-peripheral enables. No derived clocks are made. Every output is a one-cycle pulse in the master clock domain, and it fires once every N master cycles. Downstream logic uses each pulse as the enable of its flops.

The reference divider comes first and divides the master rate by a selectable power of two. The AHB, APB and flash dividers count reference pulses. The external-memory divider counts AHB pulses. The baud divider counts master cycles directly. A gate register holds one bit per consumer. After reset only the CPU, flash and SRAM bits are set. When the bypass feature is switched on and a fast interrupt is being serviced, the CPU enable skips the reference divider and fires on every master cycle.

A new divider selection is taken up only when the affected counter reaches its terminal count. A period that is already in progress therefore finishes at its old length.

Top module: `clktree_gen`

## Requirements
- R1: Reference divider select codes 0,1,2,3,4,5 give a `ref_ce` period of 1,2,4,8,16,1024 master cycles. Codes 6 and 7 give a period of 1.
- R2: AHB select codes 0,1,2 divide the reference pulses by 1,2,4. Code 3 divides by 1.
- R3: APB select codes 0,1,2,3 divide the reference pulses by 1,2,4,8.
- R4: `flash_ce` follows every reference pulse when `flash_half` is 0, and every second reference pulse when it is 1.
- R5: `baud_ce` fires every master cycle when `baud_half` is 0, and every second master cycle when it is 1. It does not depend on the reference divider.
- R6: `emb_ce` follows every AHB pulse when `emb_full` is 1, and every second AHB pulse when it is 0. Its divider leaves reset set to half rate.
- R7: Gate bit 0 enables the CPU, bit 1 the flash, bit 2 the SRAM (on AHB pulses), and bits 3 and up enable `periph_ce[i-3]` on APB pulses. After reset only bits 0 to 2 are set. A write loads the whole vector on the next edge: a 1 enables and a 0 stops.
- R8: When `fiq_bypass_en` and `fiq_active` are both 1, `cpu_ce` fires every master cycle. Otherwise it follows `ref_ce`, and `fiq_active` alone has no effect.
- R9: A selection change made in the middle of a period takes effect only at that divider's next terminal count. The period in progress is never shortened.
- R10: Each enable is a single-cycle pulse. With a ratio above 1, it never stays high on two consecutive master cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_div_sel | input | 3 | Reference divider select code |
| ahb_div_sel | input | 2 | AHB divider select code |
| apb_div_sel | input | 2 | APB divider select code |
| flash_half | input | 1 | Flash enable at half the reference rate |
| baud_half | input | 1 | Baud enable at half the master rate |
| emb_full | input | 1 | External-memory enable at the full AHB rate |
| gate_we | input | 1 | Gate register write strobe |
| gate_wdata | input | NUM_GATES | New gate vector |
| fiq_bypass_en | input | 1 | Enables the fast-interrupt CPU bypass |
| fiq_active | input | 1 | A fast interrupt is being serviced |
| ref_ce | output | 1 | Reference enable pulse |
| cpu_ce | output | 1 | Gated CPU enable pulse |
| ahb_ce | output | 1 | AHB bus enable pulse |
| apb_ce | output | 1 | APB bus enable pulse |
| flash_ce | output | 1 | Gated flash-interface enable pulse |
| baud_ce | output | 1 | Baud-rate enable pulse |
| emb_ce | output | 1 | External-memory bus enable pulse |
| sram_ce | output | 1 | Gated SRAM enable pulse |
| periph_ce | output | NUM_GATES-3 | Gated peripheral enable pulses |

## Verification
Every divider select code is swept and the settled pulse period is measured. Cascaded cases, such as the reference divider by 4 feeding APB by 8, show whether a divider counts reference pulses or master cycles, and the unused codes show whether the fallback is wired. A selection change made three cycles into a period of 16 shows whether adoption waits for the terminal count. The bypass is tried with the interrupt flag alone, with the enable alone and with both, which shows whether each term is decoded. Gate writes of 1 and then 0 show that a peripheral can be started and stopped from its reset-off state.

// File: rtl/clktree_pkg.sv
// Package: shared constants and select-code decoders for the clock enable tree.
// Assumes every ratio is a power of two, so a divider is described by its shift.
package clktree_pkg;

    localparam int SH_W  = 4;   // width of a ratio shift amount
    localparam int CNT_W = 10;  // counter width covering the largest ratio (2**10)

    typedef enum logic [2:0] {
        REFDIV_1    = 3'd0,
        REFDIV_2    = 3'd1,
        REFDIV_4    = 3'd2,
        REFDIV_8    = 3'd3,
        REFDIV_16   = 3'd4,
        REFDIV_1024 = 3'd5
    } refdiv_e;

    // Reference select code to shift; unused codes fall back to divide-by-1.
    function automatic logic [SH_W-1:0] ref_shift(input logic [2:0] code);
        case (refdiv_e'(code))
            REFDIV_2:    return SH_W'(1);
            REFDIV_4:    return SH_W'(2);
            REFDIV_8:    return SH_W'(3);
            REFDIV_16:   return SH_W'(4);
            REFDIV_1024: return SH_W'(10);
            default:     return SH_W'(0);
        endcase
    endfunction

    // AHB select code to shift; code 3 is unused and falls back to divide-by-1.
    function automatic logic [SH_W-1:0] ahb_shift(input logic [1:0] code);
        return (code == 2'd3) ? SH_W'(0) : SH_W'(code);
    endfunction

    // APB select code to shift; all four codes are used.
    function automatic logic [SH_W-1:0] apb_shift(input logic [1:0] code);
        return SH_W'(code);
    endfunction

    // One-bit half-rate select to shift.
    function automatic logic [SH_W-1:0] half_shift(input logic half);
        return SH_W'(half);
    endfunction

endpackage

// File: rtl/ce_divider.sv
// Module: power-of-two enable divider. Counts input enable pulses and emits
// one output pulse on every 2**shift-th input pulse. A new shift is adopted
// only at terminal count, so a period in progress is never cut short.
// Assumes sel_shift never exceeds CNT_W.
module ce_divider
    import clktree_pkg::*;
#(
    parameter logic [SH_W-1:0] RESET_SHIFT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_ce,
    input  logic [SH_W-1:0] sel_shift,
    output logic            out_ce
);

    logic [CNT_W-1:0] cnt_q;
    logic [SH_W-1:0]  act_q;
    logic [CNT_W-1:0] limit;
    logic             term;

    // Terminal value of the counter for the ratio currently in force.
    always_comb begin
        limit = ~({CNT_W{1'b1}} << act_q);
        term  = in_ce && (cnt_q == limit);
    end

    // Count input pulses; at terminal count wrap and adopt the requested ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= RESET_SHIFT;
        end else if (in_ce) begin
            if (term) begin
                cnt_q <= '0;
                act_q <= sel_shift;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign out_ce = term;

endmodule

// File: rtl/gate_bank.sv
// Module: per-consumer gate register. Each bit masks one base enable.
// Assumes ALWAYS_ON marks the bits that come out of reset enabled.
module gate_bank #(
    parameter int                   NUM_GATES = 8,
    parameter logic [NUM_GATES-1:0] ALWAYS_ON = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gate_we,
    input  logic [NUM_GATES-1:0] gate_wdata,
    input  logic [NUM_GATES-1:0] base_ce,
    output logic [NUM_GATES-1:0] gate_q,
    output logic [NUM_GATES-1:0] gated_ce
);

    // Hold the gate vector; a write replaces it whole.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_q <= ALWAYS_ON;
        else if (gate_we)
            gate_q <= gate_wdata;
    end

    // Mask each base enable with its own gate bit.
    for (genvar g = 0; g < NUM_GATES; g++) begin : g_mask
        assign gated_ce[g] = base_ce[g] & gate_q[g];
    end

endmodule

// File: rtl/clktree_gen.sv
// Module: clock enable tree top. Master-rate reference divider feeding the
// AHB, APB and flash dividers; external-memory divider on AHB pulses; baud
// divider on master cycles; fast-interrupt bypass on the CPU enable; gate
// bank on CPU, flash, SRAM and peripheral enables.
// Assumes NUM_GATES >= 4 (three fixed consumers plus at least one peripheral).
module clktree_gen
    import clktree_pkg::*;
#(
    parameter int NUM_GATES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           ref_div_sel,
    input  logic [1:0]           ahb_div_sel,
    input  logic [1:0]           apb_div_sel,
    input  logic                 flash_half,
    input  logic                 baud_half,
    input  logic                 emb_full,
    input  logic                 gate_we,
    input  logic [NUM_GATES-1:0] gate_wdata,
    input  logic                 fiq_bypass_en,
    input  logic                 fiq_active,
    output logic                 ref_ce,
    output logic                 cpu_ce,
    output logic                 ahb_ce,
    output logic                 apb_ce,
    output logic                 flash_ce,
    output logic                 baud_ce,
    output logic                 emb_ce,
    output logic                 sram_ce,
    output logic [NUM_GATES-4:0] periph_ce
);

    localparam int                   NUM_FIXED  = 3;
    localparam int                   NUM_PERIPH = NUM_GATES - NUM_FIXED;
    localparam logic [NUM_GATES-1:0] ALWAYS_ON  = {{NUM_PERIPH{1'b0}}, {NUM_FIXED{1'b1}}};

    logic                 flash_raw;
    logic                 cpu_raw;
    logic                 bypass;
    logic [NUM_GATES-1:0] base_ce;
    logic [NUM_GATES-1:0] gated_ce;
    logic [NUM_GATES-1:0] gate_q;

    // Reference divider on every master cycle.
    ce_divider #(.RESET_SHIFT('0)) u_ref (
        .clk(clk), .rst_n(rst_n), .in_ce(1'b1),
        .sel_shift(ref_shift(ref_div_sel)), .out_ce(ref_ce)
    );

    // Bus and flash dividers cascaded from the reference pulses.
    ce_divider #(.RESET_SHIFT('0)) u_ahb (
        .clk(clk), .rst_n(rst_n), .in_ce(ref_ce),
        .sel_shift(ahb_shift(ahb_div_sel)), .out_ce(ahb_ce)
    );
    ce_divider #(.RESET_SHIFT('0)) u_apb (
        .clk(clk), .rst_n(rst_n), .in_ce(ref_ce),
        .sel_shift(apb_shift(apb_div_sel)), .out_ce(apb_ce)
    );
    ce_divider #(.RESET_SHIFT('0)) u_flash (
        .clk(clk), .rst_n(rst_n), .in_ce(ref_ce),
        .sel_shift(half_shift(flash_half)), .out_ce(flash_raw)
    );

    // External-memory divider on AHB pulses, leaving reset at half rate.
    ce_divider #(.RESET_SHIFT(SH_W'(1))) u_emb (
        .clk(clk), .rst_n(rst_n), .in_ce(ahb_ce),
        .sel_shift(half_shift(!emb_full)), .out_ce(emb_ce)
    );

    // Baud divider directly on master cycles.
    ce_divider #(.RESET_SHIFT('0)) u_baud (
        .clk(clk), .rst_n(rst_n), .in_ce(1'b1),
        .sel_shift(half_shift(baud_half)), .out_ce(baud_ce)
    );

    // CPU enable: bypass the reference divider while a fast interrupt runs.
    always_comb begin
        bypass  = fiq_bypass_en && fiq_active;
        cpu_raw = bypass ? 1'b1 : ref_ce;
    end

    // Route each base enable to its gate slot.
    for (genvar g = 0; g < NUM_GATES; g++) begin : g_base
        if (g == 0) begin : g_cpu
            assign base_ce[g] = cpu_raw;
        end else if (g == 1) begin : g_flash
            assign base_ce[g] = flash_raw;
        end else if (g == 2) begin : g_sram
            assign base_ce[g] = ahb_ce;
        end else begin : g_periph
            assign base_ce[g] = apb_ce;
        end
    end

    gate_bank #(.NUM_GATES(NUM_GATES), .ALWAYS_ON(ALWAYS_ON)) u_gates (
        .clk(clk), .rst_n(rst_n), .gate_we(gate_we), .gate_wdata(gate_wdata),
        .base_ce(base_ce), .gate_q(gate_q), .gated_ce(gated_ce)
    );

    assign cpu_ce    = gated_ce[0];
    assign flash_ce  = gated_ce[1];
    assign sram_ce   = gated_ce[2];
    assign periph_ce = gated_ce[NUM_GATES-1:NUM_FIXED];

endmodule

// File: rtl/clktree_gen_chk.sv
// Module: assertion checker for clktree_gen, attached by bind.
// Assumes NUM_GATES >= 4 so periph_ce[0] exists.
module clktree_gen_chk #(
    parameter int NUM_GATES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           ref_div_sel,
    input logic                 baud_half,
    input logic                 gate_we,
    input logic [NUM_GATES-1:0] gate_wdata,
    input logic [NUM_GATES-1:0] gate_q,
    input logic                 fiq_bypass_en,
    input logic                 fiq_active,
    input logic                 ref_ce,
    input logic                 cpu_ce,
    input logic                 ahb_ce,
    input logic                 apb_ce,
    input logic                 flash_ce,
    input logic                 baud_ce,
    input logic                 emb_ce,
    input logic [NUM_GATES-4:0] periph_ce
);

    p_ref_div1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ce && (ref_div_sel == 3'd0 || ref_div_sel > 3'd5) |=> ref_ce);

    p_ahb_on_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ahb_ce |-> ref_ce);

    p_apb_on_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
        apb_ce |-> ref_ce);

    p_flash_on_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flash_ce |-> ref_ce);

    p_baud_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        baud_ce && !baud_half |=> baud_ce);

    p_baud_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        baud_ce && baud_half |=> !baud_ce);

    p_emb_on_ahb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        emb_ce |-> ahb_ce);

    p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_we && !gate_wdata[3] |=> !periph_ce[0]);

    p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_bypass_en && fiq_active && gate_q[0] |-> cpu_ce);

    p_ref_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ce && ref_div_sel != 3'd0 && ref_div_sel <= 3'd5 |=> !ref_ce);

endmodule

bind clktree_gen clktree_gen_chk #(.NUM_GATES(NUM_GATES)) u_chk (.*);

// File: tb/clktree_gen_tb_top.sv
// Bench: directed scenarios, one task each, measuring pulse periods at negedge.
module clktree_gen_tb_top;

    localparam int CLK_P     = 10;
    localparam int NUM_GATES = 8;
    localparam int TMO       = 5000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [2:0]           ref_div_sel = '0;
    logic [1:0]           ahb_div_sel = '0;
    logic [1:0]           apb_div_sel = '0;
    logic                 flash_half = 1'b0;
    logic                 baud_half = 1'b0;
    logic                 emb_full = 1'b0;
    logic                 gate_we = 1'b0;
    logic [NUM_GATES-1:0] gate_wdata = '0;
    logic                 fiq_bypass_en = 1'b0;
    logic                 fiq_active = 1'b0;
    logic ref_ce, cpu_ce, ahb_ce, apb_ce, flash_ce, baud_ce, emb_ce, sram_ce;
    logic [NUM_GATES-4:0] periph_ce;
    logic [8:0]           obs;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    clktree_gen #(.NUM_GATES(NUM_GATES)) dut_i (.*);

    // Observation index: 0 ref,1 cpu,2 ahb,3 apb,4 flash,5 baud,6 emb,7 sram,8 periph0
    assign obs = {periph_ce[0], sram_ce, emb_ce, baud_ce, flash_ce, apb_ce, ahb_ce, cpu_ce, ref_ce};

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(input int idx);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!obs[idx] && n < TMO);
    endtask

    // Skip some pulses to settle, then return the next interval in master cycles.
    task automatic measure(input int idx, input int skip, output int per);
        int n = 0;
        for (int k = 0; k <= skip; k++) wait_pulse(idx);
        do begin
            @(negedge clk);
            n++;
        end while (!obs[idx] && n < TMO);
        per = n;
    endtask

    task automatic count_high(input int idx, input int cycles, output int cnt);
        cnt = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (obs[idx]) cnt++;
        end
    endtask

    task automatic t_reset;
        int c;
        emb_full = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R6 emb low first cycle after reset", int'(emb_ce), 0);
        chk("R7 cpu on after reset", int'(cpu_ce), 1);
        chk("R7 sram on after reset", int'(sram_ce), 1);
        @(negedge clk);
        chk("R6 emb half-rate reset pulse", int'(emb_ce), 1);
        @(negedge clk);
        chk("R6 emb full rate after adoption", int'(emb_ce), 1);
        emb_full = 1'b0;
        count_high(8, 32, c);
        chk("R7 peripheral gated off after reset", c, 0);
        count_high(4, 8, c);
        chk("R7 flash on after reset", c, 8);
    endtask

    task automatic t_ref_codes;
        int exp_tab [8] = '{1, 2, 4, 8, 16, 1024, 1, 1};
        int p;
        for (int code = 0; code < 8; code++) begin
            ref_div_sel = 3'(code);
            measure(0, 2, p);
            chk($sformatf("R1 ref code %0d", code), p, exp_tab[code]);
        end
        ref_div_sel = 3'd0;
    endtask

    task automatic t_ahb_codes;
        int exp_tab [4] = '{1, 2, 4, 1};
        int p;
        for (int code = 0; code < 4; code++) begin
            ahb_div_sel = 2'(code);
            measure(2, 3, p);
            chk($sformatf("R2 ahb code %0d", code), p, exp_tab[code]);
        end
        ref_div_sel = 3'd1;
        ahb_div_sel = 2'd2;
        measure(2, 3, p);
        chk("R2 ahb /4 of ref /2", p, 8);
        ref_div_sel = 3'd0;
        ahb_div_sel = 2'd0;
        measure(2, 3, p);
    endtask

    task automatic t_apb_codes;
        int p;
        ref_div_sel = 3'd2;
        for (int code = 0; code < 4; code++) begin
            apb_div_sel = 2'(code);
            measure(3, 3, p);
            chk($sformatf("R3 apb code %0d on ref /4", code), p, 4 << code);
        end
        apb_div_sel = 2'd0;
        ref_div_sel = 3'd0;
        measure(3, 3, p);
    endtask

    task automatic t_flash;
        int p;
        ref_div_sel = 3'd1;
        flash_half = 1'b0;
        measure(4, 3, p);
        chk("R4 flash full on ref /2", p, 2);
        flash_half = 1'b1;
        measure(4, 3, p);
        chk("R4 flash half on ref /2", p, 4);
        flash_half = 1'b0;
        ref_div_sel = 3'd0;
        measure(4, 3, p);
    endtask

    task automatic t_baud;
        int p;
        ref_div_sel = 3'd3;
        baud_half = 1'b0;
        measure(5, 3, p);
        chk("R5 baud full ignores ref divider", p, 1);
        baud_half = 1'b1;
        measure(5, 3, p);
        chk("R5 baud half", p, 2);
        baud_half = 1'b0;
        ref_div_sel = 3'd0;
        measure(0, 2, p);
    endtask

    task automatic t_emb;
        int p;
        ahb_div_sel = 2'd1;
        emb_full = 1'b0;
        measure(6, 3, p);
        chk("R6 emb half of ahb /2", p, 4);
        emb_full = 1'b1;
        measure(6, 3, p);
        chk("R6 emb full of ahb /2", p, 2);
        emb_full = 1'b0;
        ahb_div_sel = 2'd0;
        measure(6, 3, p);
    endtask

    task automatic t_gates;
        int c;
        apb_div_sel = 2'd1;
        @(negedge clk);
        gate_we = 1'b1;
        gate_wdata = 8'b0000_1111;
        @(negedge clk);
        gate_we = 1'b0;
        count_high(8, 32, c);
        chk("R7 peripheral runs after gate write 1", c, 16);
        gate_we = 1'b1;
        gate_wdata = 8'b0000_0111;
        @(negedge clk);
        gate_we = 1'b0;
        count_high(8, 32, c);
        chk("R7 peripheral stops after gate write 0", c, 0);
        gate_we = 1'b1;
        gate_wdata = 8'b0000_0110;
        @(negedge clk);
        gate_we = 1'b0;
        count_high(1, 16, c);
        chk("R7 cpu stops after gate write 0", c, 0);
        gate_we = 1'b1;
        gate_wdata = 8'b0000_0111;
        @(negedge clk);
        gate_we = 1'b0;
        apb_div_sel = 2'd0;
    endtask

    task automatic t_bypass;
        int p;
        ref_div_sel = 3'd3;
        measure(0, 2, p);
        fiq_active = 1'b1;
        measure(1, 2, p);
        chk("R8 fiq without enable keeps divided rate", p, 8);
        fiq_bypass_en = 1'b1;
        measure(1, 1, p);
        chk("R8 bypass runs cpu at master rate", p, 1);
        fiq_active = 1'b0;
        measure(1, 2, p);
        chk("R8 cpu back to divided rate", p, 8);
        fiq_bypass_en = 1'b0;
    endtask

    task automatic t_midchange;
        int n = 3;
        int p;
        ref_div_sel = 3'd4;
        measure(0, 2, p);
        wait_pulse(0);
        repeat (3) @(negedge clk);
        ref_div_sel = 3'd0;
        do begin
            @(negedge clk);
            n++;
        end while (!obs[0] && n < TMO);
        chk("R9 period in progress keeps old length", n, 16);
        @(negedge clk);
        chk("R9 new ratio after terminal count", int'(ref_ce), 1);
    endtask

    task automatic t_pulse_width;
        int c = 0;
        int b2b = 0;
        bit prev = 1'b0;
        int p;
        ref_div_sel = 3'd3;
        measure(0, 2, p);
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (ref_ce) c++;
            if (ref_ce && prev) b2b++;
            prev = ref_ce;
        end
        chk("R10 ref /8 pulse count in 64 cycles", c, 8);
        chk("R10 no back-to-back pulses", b2b, 0);
        ref_div_sel = 3'd0;
    endtask

    initial begin
        t_reset();
        t_ref_codes();
        t_ahb_codes();
        t_apb_codes();
        t_flash();
        t_baud();
        t_emb();
        t_gates();
        t_bypass();
        t_midchange();
        t_pulse_width();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog (all requirements): run did not complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule